// File: doc/BRIEF.md
# Warp Issue Scheduler with Stall Classification

This block sits between instruction decode and the execution pipes of a multi-warp core. Every cycle it looks at a fixed pool of warp slots, each offering at most one decoded instruction, and chooses a single warp to issue. The chosen instruction goes to one of three pipe input registers: memory, simple ALU or special function. The search starts one slot past the last warp that issued and wraps around, so every warp gets a fair turn. Slots that carry a control hazard are not issued. Instead they are told to flush their instruction buffer and take the redirected PC. Slots whose operands collide in the scoreboard are held for a later cycle.

Each pipe port is a valid/ready stream. The pipe's "empty" input is its ready, and the matching `*_valid` output rises only in a cycle in which that ready is high. The payload (`issue_warp`, `issue_op`, `issue_mask`, `issue_cta`) is meaningful only while one of the valid outputs is high. Back-pressure never drops an instruction: a blocked slot receives no acknowledge and simply offers the same instruction again. When nothing issues, the cycle is put into one of three stall categories.

All statistics sit in one saturating bin array. Bins 0 to 2 are the stall categories. An issue increments bin 2 plus the number of active lanes. Issuing a barrier raises an arrival pulse. Issuing a memory barrier sets a per-warp wait flag, which the memory side clears when the barrier has drained.

Top module: `warp_issue_sched`

## Requirements
- R1: The search for a warp to issue begins at the slot after the last issuing slot and wraps modulo the slot count. After reset it begins at slot 0. The last-issued pointer changes only in a cycle that issues.
- R2: A valid slot with its hazard flag set is never issued, and its bit in `flush_vec` is high in that same cycle.
- R3: A valid, hazard-free slot with its collision flag set is not issued in that cycle.
- R4: Opcode classes 3 (load), 4 (store) and 5 (memory barrier) issue only on the memory port, and only while `mem_empty` is high.
- R5: Opcode classes 0 (ALU), 2 (dual-capable) and 6 (barrier) issue on the ALU port whenever `alu_empty` is high. Class 7 is treated as class 0.
- R6: Class 1 (special function) issues on the special-function port when `sfu_empty` is high. Class 2 issues there only when `alu_empty` is low and `sfu_empty` is high.
- R7: At most one slot is acknowledged and at most one pipe valid is high in any cycle.
- R8: A cycle with no valid, hazard-free slot increments bin 0.
- R9: A cycle in which hazard-free slots existed but all collided increments bin 1. A cycle in which a collision-free slot existed but no pipe could take any such slot increments bin 2.
- R10: Each issue increments bin 2 + popcount(`issue_mask`) and no stall bin.
- R11: Issuing class 6 raises `bar_arrive` in that cycle, with `issue_warp` and `issue_cta` naming the warp and its block.
- R12: Issuing class 5 from slot w sets `membar_wait[w]` from the next cycle. A `membar_done[w]` pulse clears it. If a set and a clear happen in the same cycle, the set wins.
- R13: Every bin stops at its all-ones value. An active-low synchronous reset clears all bins, the wait flags and the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_valid | input | NW | Slot holds a decoded instruction |
| slot_hazard | input | NW | Slot's instruction has a control hazard |
| slot_collide | input | NW | Slot's operands collide in the scoreboard |
| slot_op | input | NW*3 | Opcode class per slot |
| slot_mask | input | NW*LANES | Active-lane mask per slot |
| slot_cta | input | NW*CTA_W | Block id per slot |
| mem_empty | input | 1 | Memory pipe input register empty (ready) |
| alu_empty | input | 1 | ALU pipe input register empty (ready) |
| sfu_empty | input | 1 | Special-function pipe input register empty (ready) |
| membar_done | input | NW | Per-warp memory-barrier drained pulse |
| mem_valid | output | 1 | Issue to memory pipe |
| alu_valid | output | 1 | Issue to ALU pipe |
| sfu_valid | output | 1 | Issue to special-function pipe |
| issue_warp | output | IDW | Issued slot index |
| issue_op | output | 3 | Issued opcode class |
| issue_mask | output | LANES | Issued lane mask |
| issue_cta | output | CTA_W | Issued warp's block id |
| slot_ack | output | NW | One-hot: slot consumed this cycle |
| flush_vec | output | NW | Flush buffer and take redirect PC |
| bar_arrive | output | 1 | Barrier arrival pulse |
| membar_wait | output | NW | Warp waiting on memory barrier |
| stat_bins | output | (LANES+3)*CNT_W | Stall and lane-count bins, bin 0 in low bits |

## Verification
A stuck or skipped last-issued pointer shows up at once in `slot_ack`: the very next cycle acknowledges the wrong slot when several slots compete. A wrong stall classification or a wrong bin index appears in `stat_bins` one cycle after the cycle it concerns. A lost or stuck memory-barrier flag becomes visible on `membar_wait` one cycle after the issue or done pulse. Routing errors appear in the same cycle as a valid on the wrong port, or as a valid raised against a pipe that is not empty.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OPC_ALU    = 3'd0,
    OPC_SFU    = 3'd1,
    OPC_DUAL   = 3'd2,
    OPC_LOAD   = 3'd3,
    OPC_STORE  = 3'd4,
    OPC_MEMBAR = 3'd5,
    OPC_BAR    = 3'd6,
    OPC_RSVD   = 3'd7
  } opc_e;

  typedef struct packed {
    logic mem;
    logic alu;
    logic sfu;
  } pipe_sel_t;

  function automatic logic is_mem_class(logic [OPW-1:0] op);
    return (op == OPC_LOAD) || (op == OPC_STORE) || (op == OPC_MEMBAR);
  endfunction
endpackage

// File: rtl/wis_route.sv
module wis_route
  import wis_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic           mem_empty,
  input  logic           alu_empty,
  input  logic           sfu_empty,
  output pipe_sel_t      sel,
  output logic           fits
);
  always_comb begin
    sel = '0;
    unique case (op)
      OPC_LOAD, OPC_STORE, OPC_MEMBAR: sel.mem = mem_empty;
      OPC_SFU:                         sel.sfu = sfu_empty;
      OPC_DUAL: begin
        // ALU pipe preferred; SFU only when ALU is occupied
        sel.alu = alu_empty;
        sel.sfu = !alu_empty && sfu_empty;
      end
      default:                         sel.alu = alu_empty;
    endcase
    fits = sel.mem | sel.alu | sel.sfu;
  end
endmodule

// File: rtl/wis_pick.sv
module wis_pick #(
  parameter int NW  = 4,
  parameter int IDW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic [NW-1:0]  req,
  input  logic [IDW-1:0] last,
  output logic [NW-1:0]  grant,
  output logic [IDW-1:0] idx,
  output logic           any
);
  always_comb begin
    int k;
    grant = '0;
    idx   = '0;
    any   = 1'b0;
    for (int i = 1; i <= NW; i++) begin
      k = (int'(last) + i) % NW;
      if (!any && req[IDW'(k)]) begin
        any           = 1'b1;
        grant[IDW'(k)] = 1'b1;
        idx           = IDW'(k);
      end
    end
  end
endmodule

// File: rtl/wis_stats.sv
module wis_stats #(
  parameter int LANES = 8,
  parameter int CNT_W = 16,
  parameter int PCW   = $clog2(LANES + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         issue,
  input  logic [PCW-1:0]               pop,
  input  logic                         have_valid,
  input  logic                         have_ready,
  output logic [(LANES+3)*CNT_W-1:0]   bins_flat
);
  localparam int NBINS = LANES + 3;
  localparam int BIW   = $clog2(NBINS);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [BIW-1:0]   inc_idx;
  logic [CNT_W-1:0] bin_q [NBINS];

  // exactly one bin moves per cycle: issue bin or one stall category
  always_comb begin
    if (issue)            inc_idx = BIW'(2) + BIW'(pop);
    else if (!have_valid) inc_idx = BIW'(0);
    else if (!have_ready) inc_idx = BIW'(1);
    else                  inc_idx = BIW'(2);
  end

  for (genvar b = 0; b < NBINS; b++) begin : g_bin
    always_ff @(posedge clk) begin
      if (!rst_n)                                  bin_q[b] <= '0;
      else if (inc_idx == BIW'(b) && bin_q[b] != CMAX) bin_q[b] <= bin_q[b] + 1'b1;
    end
    assign bins_flat[b*CNT_W +: CNT_W] = bin_q[b];

    p_sat_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (bin_q[b] == CMAX) |=> (bin_q[b] == CMAX));
  end

  p_bin0_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    have_valid |=> $stable(bin_q[0]));
  p_bin1_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (have_ready || !have_valid) |=> $stable(bin_q[1]));
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import wis_pkg::*;
#(
  parameter int NW    = 4,
  parameter int LANES = 8,
  parameter int CTA_W = 3,
  parameter int CNT_W = 16,
  parameter int IDW   = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NW-1:0]              slot_valid,
  input  logic [NW-1:0]              slot_hazard,
  input  logic [NW-1:0]              slot_collide,
  input  logic [NW*OPW-1:0]          slot_op,
  input  logic [NW*LANES-1:0]        slot_mask,
  input  logic [NW*CTA_W-1:0]        slot_cta,
  input  logic                       mem_empty,
  input  logic                       alu_empty,
  input  logic                       sfu_empty,
  input  logic [NW-1:0]              membar_done,
  output logic                       mem_valid,
  output logic                       alu_valid,
  output logic                       sfu_valid,
  output logic [IDW-1:0]             issue_warp,
  output logic [OPW-1:0]             issue_op,
  output logic [LANES-1:0]           issue_mask,
  output logic [CTA_W-1:0]           issue_cta,
  output logic [NW-1:0]              slot_ack,
  output logic [NW-1:0]              flush_vec,
  output logic                       bar_arrive,
  output logic [NW-1:0]              membar_wait,
  output logic [(LANES+3)*CNT_W-1:0] stat_bins
);
  localparam int PCW = $clog2(LANES + 1);

  logic [OPW-1:0]   op_a   [NW];
  logic [LANES-1:0] mask_a [NW];
  logic [CTA_W-1:0] cta_a  [NW];
  pipe_sel_t        sel_a  [NW];
  logic [NW-1:0]    fits;
  logic [NW-1:0]    clean_v;
  logic [NW-1:0]    ready_v;
  logic [NW-1:0]    elig;
  logic [NW-1:0]    grant;
  logic [IDW-1:0]   gidx;
  logic             gany;
  logic [IDW-1:0]   last_q;
  logic [PCW-1:0]   pop;

  for (genvar w = 0; w < NW; w++) begin : g_slot
    assign op_a[w]   = slot_op[w*OPW +: OPW];
    assign mask_a[w] = slot_mask[w*LANES +: LANES];
    assign cta_a[w]  = slot_cta[w*CTA_W +: CTA_W];

    wis_route u_route (
      .op        (op_a[w]),
      .mem_empty (mem_empty),
      .alu_empty (alu_empty),
      .sfu_empty (sfu_empty),
      .sel       (sel_a[w]),
      .fits      (fits[w])
    );

    always_ff @(posedge clk) begin
      if (!rst_n)                                  membar_wait[w] <= 1'b0;
      else if (grant[w] && op_a[w] == OPC_MEMBAR)  membar_wait[w] <= 1'b1;
      else if (membar_done[w])                     membar_wait[w] <= 1'b0;
    end
  end

  assign clean_v   = slot_valid & ~slot_hazard;
  assign ready_v   = clean_v & ~slot_collide;
  assign elig      = ready_v & fits;
  assign flush_vec = slot_valid & slot_hazard;

  wis_pick #(.NW(NW), .IDW(IDW)) u_pick (
    .req   (elig),
    .last  (last_q),
    .grant (grant),
    .idx   (gidx),
    .any   (gany)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= IDW'(NW - 1);
    else if (gany) last_q <= gidx;
  end

  assign slot_ack   = grant;
  assign issue_warp = gidx;
  assign issue_op   = op_a[gidx];
  assign issue_mask = mask_a[gidx];
  assign issue_cta  = cta_a[gidx];
  assign mem_valid  = gany && sel_a[gidx].mem;
  assign alu_valid  = gany && sel_a[gidx].alu;
  assign sfu_valid  = gany && sel_a[gidx].sfu;
  assign bar_arrive = gany && (op_a[gidx] == OPC_BAR);

  always_comb begin
    pop = '0;
    for (int l = 0; l < LANES; l++) pop = pop + PCW'(issue_mask[l]);
  end

  wis_stats #(.LANES(LANES), .CNT_W(CNT_W), .PCW(PCW)) u_stats (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (gany),
    .pop        (pop),
    .have_valid (|clean_v),
    .have_ready (|ready_v),
    .bins_flat  (stat_bins)
  );

  p_ptr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !gany |=> $stable(last_q));
  p_no_flush_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_ack & flush_vec) == '0);
  p_grant_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~ready_v) == '0);
  p_mem_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_empty);
  p_mem_class_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid || sfu_valid) |-> !is_mem_class(issue_op));
  p_alu_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alu_valid |-> alu_empty);
  p_sfu_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sfu_valid |-> sfu_empty);
  p_one_pipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_valid, alu_valid, sfu_valid}));
  p_one_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_ack));
  p_membar_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && issue_op == OPC_MEMBAR) |=> membar_wait[$past(issue_warp)]);
endmodule

// File: tb/warp_issue_sched_test.sv
`timescale 1ns/1ps
module warp_issue_sched_test;
  localparam int NW = 4, LANES = 8, CTA_W = 3, CNT_W = 4, IDW = 2;
  localparam int NB = LANES + 3;

  logic clk = 0, rst_n = 0;
  logic [NW-1:0] slot_valid = 0, slot_hazard = 0, slot_collide = 0, membar_done = 0;
  logic [NW*3-1:0] slot_op = 0;
  logic [NW*LANES-1:0] slot_mask = 0;
  logic [NW*CTA_W-1:0] slot_cta = 0;
  logic mem_empty = 1, alu_empty = 1, sfu_empty = 1;
  logic mem_valid, alu_valid, sfu_valid, bar_arrive;
  logic [IDW-1:0] issue_warp;
  logic [2:0] issue_op;
  logic [LANES-1:0] issue_mask;
  logic [CTA_W-1:0] issue_cta;
  logic [NW-1:0] slot_ack, flush_vec, membar_wait;
  logic [NB*CNT_W-1:0] stat_bins;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  warp_issue_sched #(.NW(NW), .LANES(LANES), .CTA_W(CTA_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_hazard(slot_hazard),
    .slot_collide(slot_collide), .slot_op(slot_op), .slot_mask(slot_mask),
    .slot_cta(slot_cta), .mem_empty(mem_empty), .alu_empty(alu_empty),
    .sfu_empty(sfu_empty), .membar_done(membar_done), .mem_valid(mem_valid),
    .alu_valid(alu_valid), .sfu_valid(sfu_valid), .issue_warp(issue_warp),
    .issue_op(issue_op), .issue_mask(issue_mask), .issue_cta(issue_cta),
    .slot_ack(slot_ack), .flush_vec(flush_vec), .bar_arrive(bar_arrive),
    .membar_wait(membar_wait), .stat_bins(stat_bins));

  function automatic int bin(int i);
    return int'(stat_bins[i*CNT_W +: CNT_W]);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_slot(int w, bit v, bit h, bit c, logic [2:0] op, logic [7:0] m, logic [2:0] cta);
    slot_valid[w] = v; slot_hazard[w] = h; slot_collide[w] = c;
    slot_op[w*3 +: 3] = op; slot_mask[w*LANES +: LANES] = m; slot_cta[w*CTA_W +: CTA_W] = cta;
  endtask

  task automatic clear_in();
    slot_valid = 0; slot_hazard = 0; slot_collide = 0; membar_done = 0;
    slot_op = 0; slot_mask = 0; slot_cta = 0;
    mem_empty = 1; alu_empty = 1; sfu_empty = 1;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); clear_in(); rst_n = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset(); #2;
    for (int i = 0; i < NB; i++) chk("R13 reset bin", bin(i), 0);
    chk("R12 reset wait", int'(membar_wait), 0);
    chk("R7 reset ack", int'(slot_ack), 0);
  endtask

  task automatic t_idle();
    do_reset(); tick();
    chk("R8 idle bin0", bin(0), 1);
    chk("R8 idle bin1", bin(1), 0);
  endtask

  task automatic t_hazard();
    do_reset(); set_slot(1, 1, 1, 0, 3'd0, 8'h01, 0); #2;
    chk("R2 flush", int'(flush_vec), 2);
    chk("R2 no ack", int'(slot_ack), 0);
    chk("R2 no alu", int'(alu_valid), 0);
    tick(); chk("R8 hazard bin0", bin(0), 1);
  endtask

  task automatic t_collide();
    do_reset(); set_slot(2, 1, 0, 1, 3'd0, 8'h01, 0); #2;
    chk("R3 held", int'(slot_ack), 0);
    tick();
    chk("R9 bin1", bin(1), 1);
    chk("R9 bin0", bin(0), 0);
  endtask

  task automatic t_busy();
    do_reset(); set_slot(0, 1, 0, 0, 3'd3, 8'h01, 0); mem_empty = 0; #2;
    chk("R4 load waits", int'(slot_ack), 0);
    chk("R4 no alu", int'(alu_valid), 0);
    tick();
    chk("R9 bin2", bin(2), 1);
    chk("R9 bin1 quiet", bin(1), 0);
  endtask

  task automatic route(string req, logic [2:0] op, bit me, bit ae, bit se, int em, int ea, int es);
    @(negedge clk); clear_in(); set_slot(0, 1, 0, 0, op, 8'h01, 0);
    mem_empty = me; alu_empty = ae; sfu_empty = se; #2;
    chk({req, " mem"}, int'(mem_valid), em);
    chk({req, " alu"}, int'(alu_valid), ea);
    chk({req, " sfu"}, int'(sfu_valid), es);
  endtask

  task automatic t_route();
    do_reset();
    route("R4 load", 3'd3, 1, 1, 1, 1, 0, 0);
    route("R4 store busy", 3'd4, 0, 1, 1, 0, 0, 0);
    route("R4 membar", 3'd5, 1, 1, 1, 1, 0, 0);
    route("R5 alu", 3'd0, 1, 1, 1, 0, 1, 0);
    route("R5 alu busy", 3'd0, 1, 0, 1, 0, 0, 0);
    route("R5 dual", 3'd2, 1, 1, 1, 0, 1, 0);
    route("R5 rsvd", 3'd7, 1, 1, 1, 0, 1, 0);
    route("R6 dual spill", 3'd2, 1, 0, 1, 0, 0, 1);
    route("R6 sfu", 3'd1, 1, 1, 1, 0, 0, 1);
    route("R6 sfu busy", 3'd1, 1, 1, 0, 0, 0, 0);
  endtask

  task automatic t_rotate();
    do_reset();
    for (int w = 0; w < NW; w++) set_slot(w, 1, 0, 0, 3'd0, 8'h01, 0);
    #2; chk("R1 start slot0", int'(slot_ack), 1);
    tick(); chk("R1 next slot1", int'(slot_ack), 2);
    tick(); chk("R1 next slot2", int'(slot_ack), 4);
    @(negedge clk); slot_valid = 4'b1001; #2;
    chk("R1 skip to slot3", int'(slot_ack), 8);
    tick(); chk("R1 wrap slot0", int'(slot_ack), 1);
    @(negedge clk); alu_empty = 0;
    tick(); tick();
    @(negedge clk); alu_empty = 1; #2;
    chk("R1 pointer held", int'(slot_ack), 1);
  endtask

  task automatic t_onepipe();
    do_reset();
    set_slot(0, 1, 0, 0, 3'd3, 8'h01, 0);
    set_slot(1, 1, 0, 0, 3'd0, 8'h01, 0); #2;
    chk("R7 one ack", $countones(slot_ack), 1);
    chk("R7 one pipe", int'(mem_valid) + int'(alu_valid) + int'(sfu_valid), 1);
    chk("R7 slot0 mem", int'(mem_valid), 1);
  endtask

  task automatic t_barrier();
    do_reset(); set_slot(2, 1, 0, 0, 3'd6, 8'h0F, 3'd5); #2;
    chk("R11 arrive", int'(bar_arrive), 1);
    chk("R11 warp", int'(issue_warp), 2);
    chk("R11 cta", int'(issue_cta), 5);
    chk("R5 barrier alu", int'(alu_valid), 1);
    @(negedge clk); set_slot(2, 1, 0, 0, 3'd0, 8'h0F, 3'd5); #2;
    chk("R11 no arrive", int'(bar_arrive), 0);
  endtask

  task automatic t_membar();
    do_reset(); set_slot(1, 1, 0, 0, 3'd5, 8'h01, 0); #2;
    chk("R12 mem issue", int'(mem_valid), 1);
    tick(); chk("R12 set", int'(membar_wait), 2);
    @(negedge clk); clear_in(); tick();
    chk("R12 held", int'(membar_wait), 2);
    @(negedge clk); membar_done = 4'b0010; tick();
    chk("R12 cleared", int'(membar_wait), 0);
    @(negedge clk); set_slot(1, 1, 0, 0, 3'd5, 8'h01, 0); membar_done = 4'b0010; tick();
    chk("R12 set wins", int'(membar_wait), 2);
  endtask

  task automatic t_hist();
    do_reset(); set_slot(0, 1, 0, 0, 3'd0, 8'hFF, 0); tick();
    chk("R10 pop8", bin(10), 1);
    @(negedge clk); set_slot(0, 1, 0, 0, 3'd0, 8'h05, 0); tick();
    chk("R10 pop2", bin(4), 1);
    @(negedge clk); set_slot(0, 1, 0, 0, 3'd0, 8'h00, 0); tick();
    chk("R10 pop0", bin(2), 1);
    chk("R10 no stall", bin(0) + bin(1), 0);
  endtask

  task automatic t_sat();
    do_reset();
    repeat (20) tick();
    chk("R13 saturate", bin(0), 15);
    do_reset(); #2;
    chk("R13 reset clear", bin(0), 0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset(); t_idle(); t_hazard(); t_collide(); t_busy(); t_route();
    t_rotate(); t_onepipe(); t_barrier(); t_membar(); t_hist(); t_sat();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule